// File: doc/BRIEF.md
# Asynchronous Pseudo-SRAM Interface Controller

This block sits on the host side of a 16-bit asynchronous pseudo-SRAM that has two byte lanes. It runs on the system clock and produces every memory control pin from a registered state. After reset it holds the memory in its start-up condition for a programmable number of cycles. It then serves single reads and writes that arrive on a valid/ready request port. Each request carries an address, a write word, two byte-enable bits and a direction flag. A read returns its word with a one-cycle valid strobe. All memory timing values are integer parameters counted in clock cycles.

Two level inputs control power management. One holds the memory in standby, with both chip enables inactive and the contents kept. The other puts it into deep power-down by pulling the active-high enable low. When deep power-down is released, the full start-up wait runs again. The bidirectional data bus is split into an output word, an output enable and an input word. Refresh happens inside the memory and is not handled here.

Back-pressure rules: a request transfers on a rising edge where `req_valid` and `req_ready` are both high. While `req_valid` is high and `req_ready` is low, the host must keep every request field stable. `req_ready` stays low during start-up, during any access and its gaps, while a power-management input is asserted, and in deep power-down. The read response has no back-pressure: `rsp_valid` is a single-cycle pulse.

Top module: `psram_ctrl`

## Requirements
- R1: From reset, `mem_e1_n`=1 and `mem_e2`=1. `req_ready` stays 0 for the first PWRUP_CYC-1 rising edges after reset release and becomes 1 after edge PWRUP_CYC.
- R2: A read (`req_write`=0) drives `mem_e1_n`=0, `mem_e2`=1, `mem_w_n`=1 and `mem_g_n`=0 for T_ACC cycles. It captures `mem_dq_i` on the T_ACC-th edge after acceptance, and pulses `rsp_valid` high for exactly one cycle with that word on `rsp_rdata`.
- R3: A write (`req_write`=1) drives `mem_e1_n`=0, `mem_e2`=1 and `mem_w_n`=0, and keeps `mem_g_n`=1 throughout. `mem_w_n` and `mem_e1_n` rise on the same clock edge.
- R4: During a write, `mem_dq_oe` rises only after `mem_w_n` has been low with `mem_g_n` high for T_TA cycles. `mem_dq_oe` is never 1 while `mem_g_n`=0.
- R5: Write data is driven for T_DS cycles before the rising edge of `mem_w_n`/`mem_e1_n`, and stays driven for T_DH cycles after that edge.
- R6: Each lane is enabled independently. `req_be` bit 0 selects bits 7..0 (`mem_lb_n`=0) and bit 1 selects bits 15..8 (`mem_ub_n`=0). Both may be set at once, and `req_be`=00 is treated as 11.
- R7: Between the end of one access (`mem_e1_n` rising) and the next `mem_e1_n` fall, there are at least T_GAP cycles. When idle, all strobes are high, `mem_e2`=1 and `mem_dq_oe`=0.
- R8: While `pm_standby`=1 at idle, `mem_e1_n`=1, `mem_e2`=1 and `req_ready`=0, so a pending request is not accepted and memory contents are unchanged. Clearing it returns `req_ready` to 1 after one edge.
- R9: `pm_deep`=1 at idle drives `mem_e2`=0 after one edge, with `req_ready`=0. Clearing it raises `mem_e2` after one edge, and `req_ready` returns after PWRUP_CYC+1 edges.
- R10: A power-management request made during an access is taken only after the access and its gap finish. `mem_e2` stays 1 until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write word |
| req_be | input | 2 | Lane enables, bit 0 low byte, bit 1 high byte |
| rsp_valid | output | 1 | Read word valid, one-cycle pulse |
| rsp_rdata | output | 16 | Read word |
| pm_standby | input | 1 | Level: hold memory in standby |
| pm_deep | input | 1 | Level: hold memory in deep power-down |
| mem_e1_n | output | 1 | Active-low chip enable |
| mem_e2 | output | 1 | Active-high chip enable, low = deep power-down |
| mem_w_n | output | 1 | Active-low write strobe |
| mem_g_n | output | 1 | Active-low output enable |
| mem_lb_n | output | 1 | Active-low low-lane select |
| mem_ub_n | output | 1 | Active-low high-lane select |
| mem_a | output | ADDR_W | Memory address |
| mem_dq_o | output | 16 | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 16 | Data from memory |

## Verification
Every result is due a fixed number of edges after its cause. `req_ready` rises on edge PWRUP_CYC after reset release, and on edge PWRUP_CYC+1 after deep power-down is cleared. `rsp_valid` fires on the T_ACC-th edge after the accepting edge. The write data enable follows the `mem_w_n` fall by T_TA cycles, lasts T_DS cycles up to the strobe rise, and then T_DH cycles more. Inputs change at the falling edge and outputs are also sampled there. The bench counts falling edges from the accepting edge and checks at the exact index, while a pin monitor measures the lengths of the write phases and the idle gaps.

// File: rtl/psram_pkg.sv
package psram_pkg;

  // One-hot controller states; each memory pin is an OR of a few state bits.
  typedef enum logic [8:0] {
    S_PWRUP = 9'b0_0000_0001,
    S_IDLE  = 9'b0_0000_0010,
    S_RD    = 9'b0_0000_0100,
    S_WR_TA = 9'b0_0000_1000,
    S_WR_DS = 9'b0_0001_0000,
    S_WR_DH = 9'b0_0010_0000,
    S_GAP   = 9'b0_0100_0000,
    S_STBY  = 9'b0_1000_0000,
    S_DPD   = 9'b1_0000_0000
  } psram_st_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psram_cnt.sv
// Shared phase timer: loads a value and counts down to zero, then holds.
module psram_cnt #(
  parameter int              W       = 8,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= RST_VAL;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/psram_dpath.sv
// Request capture, lane decode and read capture.
module psram_dpath #(
  parameter int AW = 22,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [DW/8-1:0]  req_be,
  input  logic             capture,
  input  logic [DW-1:0]    mem_dq_i,
  output logic [AW-1:0]    addr_q,
  output logic [DW-1:0]    wdata_q,
  output logic [DW/8-1:0]  lane_q,
  output logic [DW-1:0]    rdata_q,
  output logic             rsp_q
);
  localparam int LANES = DW / 8;

  logic no_lane;
  assign no_lane = (req_be == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  // An empty lane mask is widened to all lanes.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)      lane_q[g] <= 1'b0;
      else if (accept) lane_q[g] <= no_lane | req_be[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      rsp_q <= capture;
      if (capture) rdata_q <= mem_dq_i;
    end
  end
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int PWRUP_CYC = 60000,
  parameter int T_ACC     = 14,
  parameter int T_TA      = 2,
  parameter int T_DS      = 10,
  parameter int T_DH      = 1,
  parameter int T_GAP     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  input  logic              pm_standby,
  input  logic              pm_deep,
  output logic              mem_e1_n,
  output logic              mem_e2,
  output logic              mem_w_n,
  output logic              mem_g_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [ADDR_W-1:0] mem_a,
  output logic [15:0]       mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [15:0]       mem_dq_i
);
  localparam int DW    = 16;
  localparam int LANES = DW / 8;
  localparam int MAXC  = max2(max2(max2(PWRUP_CYC, T_ACC), max2(T_TA, T_DS)),
                              max2(T_DH, T_GAP));
  localparam int CNT_W = $clog2(MAXC + 1);

  localparam logic [CNT_W-1:0] LD_PWR = CNT_W'(PWRUP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_ACC = CNT_W'(T_ACC - 1);
  localparam logic [CNT_W-1:0] LD_TA  = CNT_W'(T_TA - 1);
  localparam logic [CNT_W-1:0] LD_DS  = CNT_W'(T_DS - 1);
  localparam logic [CNT_W-1:0] LD_DH  = CNT_W'(T_DH - 1);
  localparam logic [CNT_W-1:0] LD_GAP = CNT_W'(T_GAP - 1);

  psram_st_e        st_q, st_d;
  logic             ld;
  logic [CNT_W-1:0] ld_val;
  logic             tmr_zero;
  logic             accept, capture;
  logic [LANES-1:0] lane_q;
  logic             access_on, write_low;

  // Counter comes out of reset already loaded with the start-up wait.
  psram_cnt #(.W(CNT_W), .RST_VAL(LD_PWR)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld),
    .load_val (ld_val),
    .zero     (tmr_zero)
  );

  psram_dpath #(.AW(ADDR_W), .DW(DW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .capture   (capture),
    .mem_dq_i  (mem_dq_i),
    .addr_q    (mem_a),
    .wdata_q   (mem_dq_o),
    .lane_q    (lane_q),
    .rdata_q   (rsp_rdata),
    .rsp_q     (rsp_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= S_PWRUP;
    else        st_q <= st_d;
  end

  always_comb begin
    st_d    = st_q;
    ld      = 1'b0;
    ld_val  = '0;
    accept  = 1'b0;
    capture = 1'b0;
    unique case (st_q)
      S_PWRUP: if (tmr_zero) st_d = S_IDLE;
      S_IDLE: begin
        if (pm_deep)         st_d = S_DPD;
        else if (pm_standby) st_d = S_STBY;
        else if (req_valid) begin
          accept = 1'b1;
          ld     = 1'b1;
          if (req_write) begin
            st_d   = S_WR_TA;
            ld_val = LD_TA;
          end else begin
            st_d   = S_RD;
            ld_val = LD_ACC;
          end
        end
      end
      S_RD: if (tmr_zero) begin
        capture = 1'b1;
        st_d    = S_GAP;
        ld      = 1'b1;
        ld_val  = LD_GAP;
      end
      S_WR_TA: if (tmr_zero) begin
        st_d   = S_WR_DS;
        ld     = 1'b1;
        ld_val = LD_DS;
      end
      S_WR_DS: if (tmr_zero) begin
        st_d   = S_WR_DH;
        ld     = 1'b1;
        ld_val = LD_DH;
      end
      S_WR_DH: if (tmr_zero) begin
        st_d   = S_GAP;
        ld     = 1'b1;
        ld_val = LD_GAP;
      end
      S_GAP: if (tmr_zero) st_d = S_IDLE;
      S_STBY: begin
        if (pm_deep)          st_d = S_DPD;
        else if (!pm_standby) st_d = S_IDLE;
      end
      S_DPD: if (!pm_deep) begin
        st_d   = S_PWRUP;
        ld     = 1'b1;
        ld_val = LD_PWR;
      end
      default: st_d = S_IDLE;
    endcase
  end

  // Pin decode: each is an OR of one-hot state bits.
  assign write_low = (st_q == S_WR_TA) || (st_q == S_WR_DS);
  assign access_on = write_low || (st_q == S_RD);

  assign mem_e2    = (st_q != S_DPD);
  assign mem_e1_n  = !access_on;
  assign mem_w_n   = !write_low;
  assign mem_g_n   = (st_q != S_RD);
  assign mem_dq_oe = (st_q == S_WR_DS) || (st_q == S_WR_DH);
  assign mem_lb_n  = !(access_on && lane_q[0]);
  assign mem_ub_n  = !(access_on && lane_q[1]);

  assign req_ready = (st_q == S_IDLE) && !pm_deep && !pm_standby;
endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk #(
  parameter int PWRUP_CYC = 60000
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_valid,
  input logic mem_e1_n,
  input logic mem_e2,
  input logic mem_w_n,
  input logic mem_g_n,
  input logic mem_dq_oe
);
  localparam int CW = $clog2(PWRUP_CYC + 1);
  logic [CW-1:0] since_rst;

  always_ff @(posedge clk) begin
    if (!rst_n)                          since_rst <= '0;
    else if (since_rst != CW'(PWRUP_CYC)) since_rst <= since_rst + 1'b1;
  end

  // R1
  startup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != CW'(PWRUP_CYC)) |-> (!req_ready && mem_e1_n && mem_e2));

  // R2
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R3
  strobe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_w_n) |-> $rose(mem_e1_n));

  // R4
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_g_n);

  // R4
  drive_after_wlow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (!mem_w_n && $past(!mem_w_n)));

  // R9
  deep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_e2 |-> (mem_e1_n && mem_w_n && !mem_dq_oe && !req_ready));

  // R10
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_e1_n |-> (!req_ready && mem_e2));
endmodule

bind psram_ctrl psram_ctrl_chk #(.PWRUP_CYC(PWRUP_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_e1_n  (mem_e1_n),
  .mem_e2    (mem_e2),
  .mem_w_n   (mem_w_n),
  .mem_g_n   (mem_g_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sim_psram_ctrl.sv
`timescale 1ns/1ps
module sim_psram_ctrl;
  localparam int AW = 6, PW = 40, TACC = 4, TTA = 2, TDS = 3, TDH = 2, TGAP = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, req_valid, req_ready, req_write, rsp_valid, pm_standby, pm_deep;
  logic [AW-1:0] req_addr, mem_a;
  logic [15:0] req_wdata, rsp_rdata, mem_dq_o, mem_dq_i;
  logic [1:0] req_be;
  logic mem_e1_n, mem_e2, mem_w_n, mem_g_n, mem_lb_n, mem_ub_n, mem_dq_oe;

  psram_ctrl #(.ADDR_W(AW), .PWRUP_CYC(PW), .T_ACC(TACC), .T_TA(TTA),
               .T_DS(TDS), .T_DH(TDH), .T_GAP(TGAP)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .pm_standby(pm_standby), .pm_deep(pm_deep), .mem_e1_n(mem_e1_n),
    .mem_e2(mem_e2), .mem_w_n(mem_w_n), .mem_g_n(mem_g_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_a(mem_a),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i));

  // Pin-level memory model.
  logic [15:0] model [64];
  logic [15:0] expm  [64];
  logic rd_act, wr_act, pw_act;
  logic [15:0] wlatch;
  logic [1:0]  llatch;
  assign rd_act   = !mem_e1_n && mem_e2 && mem_w_n && !mem_g_n;
  assign wr_act   = !mem_e1_n && mem_e2 && !mem_w_n;
  assign mem_dq_i = rd_act ? model[mem_a] : 16'hBAD0;

  always @(posedge clk) begin
    pw_act <= wr_act;
    if (wr_act && mem_dq_oe) begin
      wlatch <= mem_dq_o;
      llatch <= {!mem_ub_n, !mem_lb_n};
    end
    if (pw_act && !wr_act) begin
      if (llatch[0]) model[mem_a][7:0]  <= wlatch[7:0];
      if (llatch[1]) model[mem_a][15:8] <= wlatch[15:8];
    end
  end

  int checks = 0, fails = 0, cyc = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  function automatic logic [1:0] eff_be(input logic [1:0] be);
    return (be == 2'b00) ? 2'b11 : be;
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] old,
                                        input logic [15:0] d, input logic [1:0] be);
    logic [1:0] e = eff_be(be);
    return {e[1] ? d[15:8] : old[15:8], e[0] ? d[7:0] : old[7:0]};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      report();
    end
  end

  // Write-phase and gap monitor (R3, R4, R5, R7).
  int pre = 0, ds = 0, hold = 0, gap = 0;
  bit in_hold = 0, g_bad = 0, pw_m = 0, pe1 = 1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_dq_oe) check("R4 oe with G low", mem_g_n, 1);
      if (wr_act) begin
        if (!mem_g_n) g_bad = 1;
        if (!mem_dq_oe) pre++; else ds++;
      end
      if (pw_m && !wr_act) begin
        check("R3 W and E1 rise together", mem_e1_n, 1);
        check("R3 G high in write", g_bad, 0);
        check("R4 turnaround", pre, TTA);
        check("R5 data setup", ds, TDS);
        pre = 0; ds = 0; g_bad = 0; in_hold = 1; hold = 0;
      end
      if (in_hold) begin
        if (mem_dq_oe) hold++;
        else begin
          check("R5 data hold", hold, TDH);
          in_hold = 0;
        end
      end
      if (mem_e1_n) gap++;
      else begin
        if (pe1) check("R7 idle gap", (gap >= TGAP), 1);
        gap = 0;
      end
      pw_m = wr_act;
      pe1  = mem_e1_n;
    end
  end

  task automatic do_access(input bit wr, input logic [AW-1:0] a,
                           input logic [15:0] d, input logic [1:0] be);
    logic [1:0] e = eff_be(be);
    @(negedge clk);
    req_write = wr; req_addr = a; req_wdata = d; req_be = be; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    check("R6 lower lane", mem_lb_n, !e[0]);
    check("R6 upper lane", mem_ub_n, !e[1]);
    if (wr) begin
      check("R3 W low", mem_w_n, 0);
      check("R3 E1/E2 active", {mem_e1_n, mem_e2}, 2'b01);
      expm[a] = merge(expm[a], d, be);
      while (!req_ready) @(negedge clk);
    end else begin
      check("R2 read pins", {mem_e1_n, mem_e2, mem_w_n, mem_g_n}, 4'b0110);
      for (int j = 1; j <= TACC; j++) begin
        check("R2 no early rsp", rsp_valid, 0);
        @(negedge clk);
      end
      check("R2 rsp due", rsp_valid, 1);
      check("R2 read data", rsp_rdata, expm[a]);
      @(negedge clk);
      check("R2 rsp one cycle", rsp_valid, 0);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 64; i++) begin
      model[i] = 16'h0;
      expm[i]  = 16'h0;
    end
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    req_be = 2'b11; pm_standby = 0; pm_deep = 0;
    repeat (4) @(negedge clk);
    check("R1 reset pins", {mem_e1_n, mem_e2, mem_w_n, mem_g_n, mem_lb_n, mem_ub_n,
                            mem_dq_oe, req_ready, rsp_valid}, 9'b111111000);
    rst_n = 1;
    repeat (PW - 1) @(negedge clk);
    check("R1 still waiting", req_ready, 0);
    check("R1 enables high", {mem_e1_n, mem_e2}, 2'b11);
    @(negedge clk);
    check("R1 ready after wait", req_ready, 1);
    check("R7 idle pins", {mem_e1_n, mem_e2, mem_w_n, mem_g_n, mem_lb_n, mem_ub_n,
                           mem_dq_oe}, 7'b1111110);

    // Directed lane cases (R6).
    do_access(1, 6'd3, 16'h1234, 2'b11);
    do_access(0, 6'd3, 16'h0, 2'b11);
    do_access(1, 6'd3, 16'hAAEE, 2'b01);
    do_access(0, 6'd3, 16'h0, 2'b11);
    do_access(1, 6'd3, 16'h77FF, 2'b10);
    do_access(0, 6'd3, 16'h0, 2'b01);
    do_access(1, 6'd9, 16'hC0DE, 2'b00);
    do_access(0, 6'd9, 16'h0, 2'b00);

    // Standby holds off a request (R8).
    @(negedge clk);
    pm_standby = 1;
    req_write = 1; req_addr = 6'd3; req_wdata = 16'hFFFF; req_be = 2'b11; req_valid = 1;
    repeat (6) begin
      @(negedge clk);
      check("R8 not ready in standby", req_ready, 0);
      check("R8 enables high", {mem_e1_n, mem_e2}, 2'b11);
    end
    req_valid = 0;
    pm_standby = 0;
    @(negedge clk);
    check("R8 ready after standby", req_ready, 1);
    do_access(0, 6'd3, 16'h0, 2'b11);

    // Deep power-down and re-run of start-up wait (R9).
    @(negedge clk);
    pm_deep = 1;
    @(negedge clk);
    check("R9 E2 low", mem_e2, 0);
    check("R9 not ready", req_ready, 0);
    repeat (4) @(negedge clk);
    pm_deep = 0;
    @(negedge clk);
    check("R9 E2 back high", mem_e2, 1);
    repeat (PW - 1) @(negedge clk);
    check("R9 wait re-run", req_ready, 0);
    @(negedge clk);
    check("R9 ready after wait", req_ready, 1);

    // Deep request during a write is deferred (R10).
    @(negedge clk);
    req_write = 1; req_addr = 6'd12; req_wdata = 16'h5A5A; req_be = 2'b11; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    pm_deep = 1;
    expm[12] = 16'h5A5A;
    for (int j = 1; j <= TTA + TDS + TDH + TGAP + 1; j++) begin
      check("R10 E2 held during access", mem_e2, 1);
      @(negedge clk);
    end
    check("R10 deep taken after access", mem_e2, 0);
    pm_deep = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    do_access(0, 6'd12, 16'h0, 2'b11);

    // Random traffic.
    for (int n = 0; n < 80; n++) begin
      do_access(1'($urandom_range(0, 1)), AW'($urandom_range(0, 15)),
                16'($urandom), 2'($urandom_range(0, 3)));
    end
    for (int i = 0; i < 16; i++) do_access(0, AW'(i), 16'h0, 2'b11);

    repeat (4) @(negedge clk);
    report();
  end
endmodule